// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. After reset it drives the mandatory start-up command sequence into the memory. It holds the clock-enable low until the supplies and clock have been reported stable for a programmed number of cycles. It then raises clock-enable and issues a precharge of all banks. Next it programs the extended mode word to turn the delay-locked loop on, and then programs the base mode word with the loop-reset bit set. A second precharge follows, then two auto-refresh commands, and last a base mode load with the loop-reset bit cleared. It signals completion only after both the final load has settled and the loop-lock interval has run out.

Every wait (power-up settle, precharge time, mode-load time, refresh time, loop lock) is a parameter in clock cycles. The minimum gap rule therefore travels with the clock rate chosen at integration. The burst length code, burst type and read-latency code are parameters that are packed into the base mode word. All outputs come straight from registers. On every cycle that does not carry one of the listed commands, the command output is NOP.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, cke is 0, cmdCode is NOP (2'b00), bank and addr are all zero, and initDone is 0. Asserting reset at any point in the sequence returns the block to this state and restarts the power-up wait.
- R2: cke stays 0 until pwrStable has been sampled high on PWRUP_CYC consecutive clock edges. A low sample restarts the count. cke rises on the next edge after the last counted one, with cmdCode NOP.
- R3: One cycle after cke rises, cmdCode shows PRECHARGE ALL (2'b01) with addr bit 10 set, all other addr bits 0, and bank 2'b00.
- R4: TRP_CYC cycles after that precharge, cmdCode shows LOAD MODE (2'b10) with bank 2'b01 and addr all zero (the extended mode word with the loop enabled).
- R5: TMRD_CYC cycles later, LOAD MODE appears with bank 2'b00. Its addr has bit 8 (loop reset) set, bits 6:4 = CAS_CODE, bit 3 = BURST_TYPE, bits 2:0 = BURST_CODE, and all other bits 0.
- R6: A second PRECHARGE ALL follows TMRD_CYC cycles after R5. AUTO REFRESH (2'b11, bank and addr zero) follows TRP_CYC cycles later, and a second AUTO REFRESH TRFC_CYC cycles after the first.
- R7: TRFC_CYC cycles after the second refresh, LOAD MODE with bank 2'b00 carries the R5 word with bit 8 cleared.
- R8: initDone rises at the later of TMRD_CYC cycles after the final load and DLL_LOCK_CYC cycles after the loop-reset load. It then stays 1 until reset, with cke 1 and cmdCode NOP.
- R9: Exactly seven non-NOP commands are issued per sequence. Every other cycle carries NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrStable | input | 1 | Supplies, reference and clock are stable |
| cke | output | 1 | Clock enable to the memory |
| cmdCode | output | 2 | Command: 00 NOP, 01 precharge all, 10 load mode, 11 auto refresh |
| bank | output | BANK_W | Bank address; selects the mode word during loads |
| addr | output | ADDR_W | Address bus; carries the mode words |
| initDone | output | 1 | Initialization finished, memory ready |

## Verification
The bench drops pwrStable partway through the power-up wait. A design that kept counting instead of restarting would raise cke early. It checks the exact cycle of each of the seven commands, their bank selects and mode words. A wrong gap, a swapped extended and base load, or a loop-reset bit left set in the final word each show up at a specific cycle. Two instances are built, one where the loop-lock interval dominates and one where the final load time dominates. A design that gated completion on only one of the two would finish early in one of them. A reset in mid-sequence must drop cke at once and rerun the full power-up wait.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_PALL = 2'b01,
    CMD_LMR  = 2'b10,
    CMD_AREF = 2'b11
  } cmdCode_e;

  // which address word the datapath drives with the command
  typedef enum logic [1:0] {
    WORD_ZERO,
    WORD_PALL,
    WORD_BASE_DLLRST,
    WORD_BASE_RUN
  } wordSel_e;

  // which interval the wait counter is loaded with
  typedef enum logic [1:0] {
    WAIT_PWR,
    WAIT_TRP,
    WAIT_TMRD,
    WAIT_TRFC
  } waitSel_e;

  typedef struct packed {
    cmdCode_e   cmd;
    logic [1:0] bankSel;
    wordSel_e   word;
    logic       loadWait;
    waitSel_e   waitSel;
    logic       decWait;
    logic       startDll;
    logic       ckeOn;
    logic       doneOn;
  } seqStrobe_t;

endpackage

// File: rtl/ddr_init_dp.sv
module ddr_init_dp
  import ddr_init_pkg::*;
#(
  parameter int PWRUP_CYC    = 40000,
  parameter int TRP_CYC      = 3,
  parameter int TMRD_CYC     = 2,
  parameter int TRFC_CYC     = 15,
  parameter int DLL_LOCK_CYC = 200,
  parameter int ADDR_W       = 13,
  parameter int BANK_W       = 2,
  parameter logic [2:0] BURST_CODE = 3'b011,
  parameter logic       BURST_TYPE = 1'b0,
  parameter logic [2:0] CAS_CODE   = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        stb,
  output logic              waitZero,
  output logic              dllDone,
  output logic              cke,
  output logic [1:0]        cmdCode,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam int WAIT_W     = $clog2(PWRUP_CYC + TRP_CYC + TMRD_CYC + TRFC_CYC + 1);
  localparam int DLL_W      = $clog2(DLL_LOCK_CYC + 1);
  localparam int DLLRST_BIT = 8;
  localparam int PALL_BIT   = 10;
  localparam logic [ADDR_W-1:0] RUN_WORD  = ADDR_W'({CAS_CODE, BURST_TYPE, BURST_CODE});
  localparam logic [ADDR_W-1:0] RST_WORD  = RUN_WORD | (ADDR_W'(1) << DLLRST_BIT);
  localparam logic [ADDR_W-1:0] PALL_WORD = ADDR_W'(1) << PALL_BIT;

  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitLoad;
  logic [DLL_W-1:0]  dllCnt;
  logic              dllRun;
  logic [ADDR_W-1:0] addrD;

  // command states load gap-2 so the next command lands exactly gap cycles later
  always_comb begin
    unique case (stb.waitSel)
      WAIT_PWR:  waitLoad = WAIT_W'(PWRUP_CYC - 1);
      WAIT_TRP:  waitLoad = WAIT_W'(TRP_CYC - 2);
      WAIT_TMRD: waitLoad = WAIT_W'(TMRD_CYC - 2);
      default:   waitLoad = WAIT_W'(TRFC_CYC - 2);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waitCnt <= WAIT_W'(PWRUP_CYC - 1);
    end else if (stb.loadWait) begin
      waitCnt <= waitLoad;
    end else if (stb.decWait && waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign waitZero = (waitCnt == '0);

  // loop-lock interval, started by the loop-reset load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dllCnt <= '0;
      dllRun <= 1'b0;
    end else if (stb.startDll) begin
      dllCnt <= DLL_W'(DLL_LOCK_CYC - 2);
      dllRun <= 1'b1;
    end else if (dllRun && dllCnt != '0) begin
      dllCnt <= dllCnt - 1'b1;
    end
  end

  assign dllDone = dllRun && (dllCnt == '0);

  always_comb begin
    unique case (stb.word)
      WORD_PALL:        addrD = PALL_WORD;
      WORD_BASE_DLLRST: addrD = RST_WORD;
      WORD_BASE_RUN:    addrD = RUN_WORD;
      default:          addrD = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke      <= 1'b0;
      cmdCode  <= CMD_NOP;
      bank     <= '0;
      addr     <= '0;
      initDone <= 1'b0;
    end else begin
      cke      <= cke | stb.ckeOn;
      cmdCode  <= stb.cmd;
      bank     <= BANK_W'(stb.bankSel);
      addr     <= addrD;
      initDone <= initDone | stb.doneOn;
    end
  end

  // R2: no command reaches the memory while clock-enable is low
  a_r2_cmd_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode != CMD_NOP) |-> cke);

  // R3, R6: every precharge selects all banks
  a_r3_pall_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == CMD_PALL) |-> (addr[PALL_BIT] && bank == '0));

  // R5: mode loads only target base or extended word
  a_r5_lmr_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == CMD_LMR) |-> (bank[BANK_W-1:1] == '0));

  // R8: completion is sticky and quiet
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    initDone |=> initDone);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    initDone |-> (cmdCode == CMD_NOP && cke));

endmodule

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrStable,
  input  logic       waitZero,
  input  logic       dllDone,
  output seqStrobe_t stb
);

  typedef enum logic [4:0] {
    sPwr, sCke,
    sPre1, sWPre1,
    sExt, sWExt,
    sMrRst, sWMrRst,
    sPre2, sWPre2,
    sRef1, sWRef1,
    sRef2, sWRef2,
    sMrRun, sWMrRun,
    sDone
  } seqState_e;

  seqState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= sPwr;
    else        stateQ <= stateD;
  end

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    unique case (stateQ)
      sPwr: begin
        if (!pwrStable) begin
          stb.loadWait = 1'b1;
          stb.waitSel  = WAIT_PWR;
        end else if (waitZero) begin
          stateD = sCke;
        end else begin
          stb.decWait = 1'b1;
        end
      end
      sCke: begin
        stb.ckeOn = 1'b1;
        stateD    = sPre1;
      end
      sPre1, sPre2: begin
        stb.cmd      = CMD_PALL;
        stb.word     = WORD_PALL;
        stb.loadWait = 1'b1;
        stb.waitSel  = WAIT_TRP;
        stateD       = (stateQ == sPre1) ? sWPre1 : sWPre2;
      end
      sExt: begin
        stb.cmd      = CMD_LMR;
        stb.bankSel  = 2'b01;
        stb.word     = WORD_ZERO;
        stb.loadWait = 1'b1;
        stb.waitSel  = WAIT_TMRD;
        stateD       = sWExt;
      end
      sMrRst: begin
        stb.cmd      = CMD_LMR;
        stb.word     = WORD_BASE_DLLRST;
        stb.loadWait = 1'b1;
        stb.waitSel  = WAIT_TMRD;
        stb.startDll = 1'b1;
        stateD       = sWMrRst;
      end
      sRef1, sRef2: begin
        stb.cmd      = CMD_AREF;
        stb.loadWait = 1'b1;
        stb.waitSel  = WAIT_TRFC;
        stateD       = (stateQ == sRef1) ? sWRef1 : sWRef2;
      end
      sMrRun: begin
        stb.cmd      = CMD_LMR;
        stb.word     = WORD_BASE_RUN;
        stb.loadWait = 1'b1;
        stb.waitSel  = WAIT_TMRD;
        stateD       = sWMrRun;
      end
      sWPre1, sWExt, sWMrRst, sWPre2, sWRef1, sWRef2: begin
        if (waitZero) begin
          unique case (stateQ)
            sWPre1:  stateD = sExt;
            sWExt:   stateD = sMrRst;
            sWMrRst: stateD = sPre2;
            sWPre2:  stateD = sRef1;
            sWRef1:  stateD = sRef2;
            default: stateD = sMrRun;
          endcase
        end else begin
          stb.decWait = 1'b1;
        end
      end
      sWMrRun: begin
        if (!waitZero)    stb.decWait = 1'b1;
        else if (dllDone) stateD = sDone;
      end
      sDone: begin
        stb.doneOn = 1'b1;
      end
      default: stateD = sPwr;
    endcase
  end

  // R8: the sequence cannot finish before the loop-lock interval expired
  a_r8_dll_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == sDone) |-> dllDone);

  // R2: clock-enable rises only out of a completed power-up wait
  a_r2_cke_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == sCke) |-> ($past(stateQ) == sPwr && $past(pwrStable)));

  // R9: at most one command strobe per cycle and never alongside the wait decrement
  a_r9_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.loadWait, stb.decWait, stb.ckeOn, stb.doneOn}));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int PWRUP_CYC    = 40000,
  parameter int TRP_CYC      = 3,
  parameter int TMRD_CYC     = 2,
  parameter int TRFC_CYC     = 15,
  parameter int DLL_LOCK_CYC = 200,
  parameter int ADDR_W       = 13,
  parameter int BANK_W       = 2,
  parameter logic [2:0] BURST_CODE = 3'b011,
  parameter logic       BURST_TYPE = 1'b0,
  parameter logic [2:0] CAS_CODE   = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrStable,
  output logic              cke,
  output logic [1:0]        cmdCode,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  seqStrobe_t stb;
  logic       waitZero;
  logic       dllDone;

  ddr_init_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrStable (pwrStable),
    .waitZero  (waitZero),
    .dllDone   (dllDone),
    .stb       (stb)
  );

  ddr_init_dp #(
    .PWRUP_CYC    (PWRUP_CYC),
    .TRP_CYC      (TRP_CYC),
    .TMRD_CYC     (TMRD_CYC),
    .TRFC_CYC     (TRFC_CYC),
    .DLL_LOCK_CYC (DLL_LOCK_CYC),
    .ADDR_W       (ADDR_W),
    .BANK_W       (BANK_W),
    .BURST_CODE   (BURST_CODE),
    .BURST_TYPE   (BURST_TYPE),
    .CAS_CODE     (CAS_CODE)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .waitZero (waitZero),
    .dllDone  (dllDone),
    .cke      (cke),
    .cmdCode  (cmdCode),
    .bank     (bank),
    .addr     (addr),
    .initDone (initDone)
  );

endmodule

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int P    = 20;
  localparam int TRP  = 3;
  localparam int TMRD = 2;
  localparam int TRFC = 6;
  localparam int LCK  = 30;
  localparam int LCK2 = 5;
  localparam logic [2:0] BL = 3'b010;
  localparam logic       BT = 1'b1;
  localparam logic [2:0] CL = 3'b011;

  localparam logic [12:0] W_PALL = 13'h400;
  localparam logic [12:0] W_RUN  = {6'b0, CL, BT, BL};
  localparam logic [12:0] W_RST  = W_RUN | 13'h100;

  // {cmd, bank, addr, gap from previous event (first: from cke rise)}
  localparam logic [32:0] VEC [0:6] = '{
    {2'b01, 2'b00, W_PALL, 16'(1)},
    {2'b10, 2'b01, 13'h000, 16'(TRP)},
    {2'b10, 2'b00, W_RST,  16'(TMRD)},
    {2'b01, 2'b00, W_PALL, 16'(TMRD)},
    {2'b11, 2'b00, 13'h000, 16'(TRP)},
    {2'b11, 2'b00, 13'h000, 16'(TRFC)},
    {2'b10, 2'b00, W_RUN,  16'(TRFC)}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrStable = 1'b0;
  logic cke, initDone, cke2, initDone2;
  logic [1:0] cmdCode, cmdCode2, bank, bank2;
  logic [12:0] addr, addr2;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_init_seq #(.PWRUP_CYC(P), .TRP_CYC(TRP), .TMRD_CYC(TMRD), .TRFC_CYC(TRFC),
    .DLL_LOCK_CYC(LCK), .BURST_CODE(BL), .BURST_TYPE(BT), .CAS_CODE(CL)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwrStable(pwrStable), .cke(cke), .cmdCode(cmdCode),
    .bank(bank), .addr(addr), .initDone(initDone));

  ddr_init_seq #(.PWRUP_CYC(P), .TRP_CYC(TRP), .TMRD_CYC(TMRD), .TRFC_CYC(TRFC),
    .DLL_LOCK_CYC(LCK2), .BURST_CODE(BL), .BURST_TYPE(BT), .CAS_CODE(CL)) dut2_i (
    .clk(clk), .rst_n(rst_n), .pwrStable(pwrStable), .cke(cke2), .cmdCode(cmdCode2),
    .bank(bank2), .addr(addr2), .initDone(initDone2));

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int nLog = 0;
  int logCyc [0:15];
  logic [16:0] logVal [0:15];
  int ckeAt = -1, doneAt = -1, done2At = -1, fin2At = -1;
  bit finished = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmdCode != 2'b00 && nLog < 16) begin
        logCyc[nLog] = cyc;
        logVal[nLog] = {cmdCode, bank, addr};
        nLog++;
      end
      if (cke && ckeAt < 0) ckeAt = cyc;
      if (initDone && doneAt < 0) doneAt = cyc;
      if (initDone2 && done2At < 0) done2At = cyc;
      if (cmdCode2 == 2'b10 && bank2 == 2'b00 && !addr2[8]) fin2At = cyc;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic string tagOf(input int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3, 4, 5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic clearLog();
    nLog = 0; ckeAt = -1; doneAt = -1; done2At = -1; fin2At = -1;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int s0;
    int expT;
    int mrRstT;
    int expDone;
    // R1: reset state
    waitCycles(3);
    check(cke == 0, "R1 cke in reset", cke, 0);
    check(cmdCode == 0, "R1 cmd in reset", cmdCode, 0);
    check(bank == 0 && addr == 0, "R1 bus in reset", int'(addr), 0);
    check(initDone == 0 && initDone2 == 0, "R1 done in reset", initDone, 0);
    rst_n = 1'b1;
    waitCycles(1);
    check(cke == 0 && cmdCode == 0, "R1 first cycle after reset", cke, 0);
    // R2: no progress without pwrStable, restart on drop
    waitCycles(P + 5);
    check(cke == 0, "R2 cke low while unstable", cke, 0);
    pwrStable = 1'b1;
    waitCycles(P - 3);
    pwrStable = 1'b0;
    waitCycles(2);
    check(cke == 0, "R2 cke low after drop", cke, 0);
    pwrStable = 1'b1;
    s0 = cyc;
    for (int k = 0; k < 400 && !(initDone && initDone2); k++) waitCycles(1);
    waitCycles(30);
    check(ckeAt == s0 + P + 1, "R2 cke rise cycle", ckeAt, s0 + P + 1);
    // vector table walk: R3..R7
    expT = ckeAt;
    mrRstT = 0;
    for (int i = 0; i < 7; i++) begin
      expT += int'(VEC[i][15:0]);
      if (i == 2) mrRstT = expT;
      check(logCyc[i] == expT, {tagOf(i), " cycle"}, logCyc[i], expT);
      check(logVal[i][16:15] == VEC[i][32:31], {tagOf(i), " cmd"}, logVal[i][16:15], VEC[i][32:31]);
      check(logVal[i][14:13] == VEC[i][30:29], {tagOf(i), " bank"}, logVal[i][14:13], VEC[i][30:29]);
      check(logVal[i][12:0] == VEC[i][28:16], {tagOf(i), " addr"}, logVal[i][12:0], VEC[i][28:16]);
    end
    check(nLog == 7, "R9 command count", nLog, 7);
    // R8: completion gated by the later of the two intervals
    expDone = (expT + TMRD > mrRstT + LCK) ? expT + TMRD : mrRstT + LCK;
    check(doneAt == expDone, "R8 done cycle (lock dominates)", doneAt, expDone);
    check(done2At == fin2At + TMRD, "R8 done cycle (load dominates)", done2At, fin2At + TMRD);
    check(initDone && cke && cmdCode == 0, "R8 done state", initDone, 1);
    // R1: reset in mid-sequence
    rst_n = 1'b0;
    waitCycles(1);
    clearLog();
    rst_n = 1'b1;
    s0 = cyc;
    waitCycles(P + 5);
    rst_n = 1'b0;
    waitCycles(1);
    check(cke == 0 && cmdCode == 0 && initDone == 0, "R1 mid-sequence reset", cke, 0);
    clearLog();
    rst_n = 1'b1;
    s0 = cyc;
    waitCycles(P + 4);
    check(ckeAt == s0 + P + 1, "R1 restart wait after reset", ckeAt, s0 + P + 1);
    check(nLog >= 1 && logCyc[0] == s0 + P + 2, "R3 precharge after restart", logCyc[0], s0 + P + 2);
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

endmodule